// File: doc/BRIEF.md
# Pipelined Q15 Fractional Divider

This block divides one signed Q15 fraction by another. Both operands are 16-bit two's complement words with an implied scale of 2^15, so each one stands for a value in [-1, 1). The result is the quotient in the same format, together with the matching remainder. The scale is applied by widening the dividend into a 32-bit partial remainder and shifting it left by fifteen places. Sixteen add-or-subtract steps then produce one quotient digit each. Each digit is -1 or +1 and is stored as a 0 or 1 bit. A final correction stage turns the digit string into a plain two's complement quotient and makes the remainder consistent with truncating division.

Every step, and the correction, has its own register. A new operand pair can therefore be accepted on every clock, and each result leaves the block exactly 17 clocks after its operands entered. A valid bit travels with every operand pair. A zero divisor sets a flag that comes out in the same cycle as that pair's result.

A result has meaning only when the true quotient lies in [-1, 1). The block does not saturate results outside that range; the user keeps the divisor magnitude above the dividend magnitude.

Top module: `q15_divider`

## Requirements
- R1: For a dividend a and a divisor b whose true quotient a/b lies in [-1, 1), the quotient output equals the low 16 bits of trunc((a * 2^15) / b), computed with a and b read as signed 16-bit integers.
- R2: For those same operand pairs, the remainder output equals (a * 2^15) - quotient * b, taken as a signed 16-bit value. It is therefore zero or carries the sign of a, and its magnitude is below the magnitude of b.
- R3: The result of an operand pair sampled with the input valid high appears with the output valid high exactly 17 rising clock edges later.
- R4: Operand pairs presented on consecutive clocks all produce correct results on consecutive clocks, in the order they were given.
- R5: The divide-by-zero output is 1 together with the output valid for a pair whose divisor is 0x0000. It is 0 for any pair with a nonzero divisor, and 0 whenever the output valid is low. The quotient and remainder of a zero-divisor pair are unspecified.
- R6: While the active-low reset is asserted and after it is released, with no valid input yet, the output valid and the divide-by-zero output read 0.
- R7: Exact quotients give a remainder of 0x0000, including the cases where a partial remainder passes through zero, for example 0x2000 / 0x4000 = 0x4000 and 0x4000 / 0x8000 = 0xC000.
- R8: A cycle with the input valid low produces no output valid 17 cycles later, and no output valid is ever raised without a matching input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid and flag pipeline |
| inValid | input | 1 | Operand pair is presented this cycle |
| dividend | input | 16 | Q15 dividend, two's complement |
| divisor | input | 16 | Q15 divisor, two's complement |
| quotient | output | 16 | Q15 quotient, truncated toward zero |
| remainder | output | 16 | Remainder of the scaled division, two's complement |
| outValid | output | 1 | Quotient and remainder hold a result |
| divZero | output | 1 | The result belongs to a zero divisor |

## Verification
The bench builds the block with its default width of 16, which is the Q15 case. With that width, every pairing of the extreme values 0x8000, 0x7FFF, 0x0001, 0xFFFF and zero can be driven back to back. This exercises the correction paths where the remainder equals plus or minus the divisor, the paths that repair its sign, and the most negative divisor. Random operand pairs with random idle gaps are then run against a bench model of truncating division. That run checks quotient and remainder on the in-range pairs and the 17-cycle timing on every pair.

// File: rtl/q15div_pkg.sv
package q15div_pkg;

  // Strobes from the control pipeline to the datapath
  typedef struct packed {
    logic fixEn;     // last iteration stage holds valid data
    logic resValid;  // correction registers hold a result
    logic resDz;     // that result came from a zero divisor
  } ctrlStrobe_t;

endpackage

// File: rtl/q15div_ctrl.sv
module q15div_ctrl #(
  parameter int unsigned STEPS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  input  logic                     divIsZero,
  output logic [STEPS-1:0]         stageEn,
  output q15div_pkg::ctrlStrobe_t  strobe,
  output logic                     outValid,
  output logic                     outDz
);

  logic [STEPS-1:0] vPipe;
  logic [STEPS-1:0] zPipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vPipe    <= '0;
      zPipe    <= '0;
      outValid <= 1'b0;
      outDz    <= 1'b0;
    end else begin
      vPipe    <= {vPipe[STEPS-2:0], inValid};
      zPipe    <= {zPipe[STEPS-2:0], inValid & divIsZero};
      outValid <= vPipe[STEPS-1];
      outDz    <= zPipe[STEPS-1] & vPipe[STEPS-1];
    end
  end

  // Stage i loads when valid data enters it
  assign stageEn = {vPipe[STEPS-2:0], inValid};

  always_comb begin
    strobe.fixEn    = vPipe[STEPS-1];
    strobe.resValid = outValid;
    strobe.resDz    = outDz;
  end

  AST_DZ_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    outDz |-> outValid); // R5

endmodule

// File: rtl/q15div_dp.sv
module q15div_dp #(
  parameter int unsigned W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W-1:0]             dividend,
  input  logic [W-1:0]             divisor,
  input  logic [W-1:0]             stageEn,
  input  q15div_pkg::ctrlStrobe_t  strobe,
  output logic [W-1:0]             quotOut,
  output logic [W-1:0]             remOut
);

  localparam int unsigned PW   = 2 * W;   // partial remainder width
  localparam int unsigned FRAC = W - 1;   // fractional bits of Q format
  localparam int unsigned XW   = PW + 2;  // width used by checks

  for (genvar i = 0; i < W; i++) begin : gStep
    logic [PW-1:0] ppPrev;
    logic [W-1:0]  qPrev;
    logic [W-1:0]  dPrev;
    logic [W-1:0]  aPrev;
    logic [PW-1:0] ddExp;
    logic [PW-1:0] ppShift;
    logic          signsDiffer;
    logic [PW-1:0] ppR;
    logic [W-1:0]  qR;
    logic [W-1:0]  dR;
    logic [W-1:0]  aR;

    if (i == 0) begin : gFirst
      // Scaled, sign-extended dividend starts the partial remainder
      assign ppPrev = {dividend[W-1], dividend, {FRAC{1'b0}}};
      assign qPrev  = '0;
      assign dPrev  = divisor;
      assign aPrev  = dividend;
    end else begin : gNext
      assign ppPrev = gStep[i-1].ppR;
      assign qPrev  = gStep[i-1].qR;
      assign dPrev  = gStep[i-1].dR;
      assign aPrev  = gStep[i-1].aR;
    end

    assign ddExp       = {dPrev, {W{1'b0}}};
    assign ppShift     = {ppPrev[PW-2:0], 1'b0};
    assign signsDiffer = ppPrev[PW-1] ^ dPrev[W-1];

    always_ff @(posedge clk) begin
      if (stageEn[i]) begin
        if (signsDiffer) begin
          qR  <= {qPrev[W-2:0], 1'b0};
          ppR <= ppShift + ddExp;
        end else begin
          qR  <= {qPrev[W-2:0], 1'b1};
          ppR <= ppShift - ddExp;
        end
        dR <= dPrev;
        aR <= aPrev;
      end
    end
  end

  logic [PW-1:0] ppLast;
  logic [W-1:0]  qLast, dLast, aLast;
  assign ppLast = gStep[W-1].ppR;
  assign qLast  = gStep[W-1].qR;
  assign dLast  = gStep[W-1].dR;
  assign aLast  = gStep[W-1].aR;

  logic [W-1:0] qFix, rFix, negD;
  logic [W-1:0] dFin, aFin;

  always_comb begin
    negD = -dLast;
    qFix = {qLast[W-2:0], 1'b1};   // digits {-1,+1} to two's complement
    rFix = ppLast[PW-1:W];
    if (rFix == dLast) begin
      qFix = qFix + 1'b1;
      rFix = '0;
    end else if (rFix == negD) begin
      qFix = qFix - 1'b1;
      rFix = '0;
    end
    if ((rFix != '0) && (rFix[W-1] ^ aLast[W-1])) begin
      if (qFix[W-1]) begin
        qFix = qFix + 1'b1;
        rFix = rFix - dLast;
      end else begin
        qFix = qFix - 1'b1;
        rFix = rFix + dLast;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fixEn) begin
      quotOut <= qFix;
      remOut  <= rFix;
      dFin    <= dLast;
      aFin    <= aLast;
    end
  end

  // Quantities used by the checks below
  logic signed [W:0]    absA, absD, absR, sa, sd, sr;
  logic signed [XW-1:0] recon, scaledA;
  logic                 inRange;

  always_comb begin
    sa      = (W+1)'($signed(aFin));
    sd      = (W+1)'($signed(dFin));
    sr      = (W+1)'($signed(remOut));
    absA    = (sa < 0) ? -sa : sa;
    absD    = (sd < 0) ? -sd : sd;
    absR    = (sr < 0) ? -sr : sr;
    inRange = absA < absD;
    recon   = XW'($signed(quotOut)) * XW'($signed(dFin)) + XW'($signed(remOut));
    scaledA = {{(XW-W-FRAC){aFin[W-1]}}, aFin, {FRAC{1'b0}}};
  end

  AST_RESULT_RECONSTRUCTS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.resValid && !strobe.resDz && inRange) |-> (recon == scaledA)); // R1
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.resValid && !strobe.resDz && inRange && remOut != '0)
      |-> (remOut[W-1] == aFin[W-1])); // R2
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.resValid && !strobe.resDz && inRange) |-> (absR < absD)); // R2

endmodule

// File: rtl/q15_divider.sv
module q15_divider #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         outValid,
  output logic         divZero
);

  q15div_pkg::ctrlStrobe_t strobe;
  logic [W-1:0]            stageEn;
  logic                    divIsZero;

  assign divIsZero = (divisor == '0);

  q15div_ctrl #(.STEPS(W)) uCtrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .divIsZero (divIsZero),
    .stageEn   (stageEn),
    .strobe    (strobe),
    .outValid  (outValid),
    .outDz     (divZero)
  );

  q15div_dp #(.W(W)) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .dividend (dividend),
    .divisor  (divisor),
    .stageEn  (stageEn),
    .strobe   (strobe),
    .quotOut  (quotient),
    .remOut   (remainder)
  );

endmodule

// File: tb/q15_divider_test.sv
module q15_divider_test;

  localparam int W       = 16;
  localparam int LATENCY = 17;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic [W-1:0] quotient, remainder;
  logic         outValid, divZero;

  always #5ns clk = ~clk;

  q15_divider #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder),
    .outValid(outValid), .divZero(divZero)
  );

  typedef struct {
    int           issue;
    bit           chk;
    bit           dz;
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic [W-1:0] a;
    logic [W-1:0] b;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int nTests = 0;
  int nFail = 0;
  bit monOn = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input bit v);
    expItem_t e;
    longint num, den, qt, rt;
    @(negedge clk);
    inValid  = v;
    dividend = a;
    divisor  = b;
    if (v) begin
      e.issue = cyc;
      e.a = a;
      e.b = b;
      e.dz = (b == '0);
      e.chk = 1'b0;
      e.q = '0;
      e.r = '0;
      if (!e.dz) begin
        num = longint'($signed(a)) * 32768;
        den = longint'($signed(b));
        qt  = num / den;
        rt  = num % den;
        e.chk = (qt >= -32768) && (qt <= 32767);
        e.q = W'(qt);
        e.r = W'(rt);
      end
      expQ.push_back(e);
    end
  endtask

  // Monitor: pops and compares every result as it appears
  always @(negedge clk) begin
    if (monOn) begin
      if (!outValid && divZero)
        check(1'b0, "R5", "divZero without outValid", {{(W-1){1'b0}}, divZero}, '0);
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "outValid with no pending input", 16'h1, 16'h0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(cyc == e.issue + LATENCY, "R3", "latency (cycles)",
                W'(cyc - e.issue), W'(LATENCY));
          check(divZero == e.dz, "R5", "divZero flag",
                {{(W-1){1'b0}}, divZero}, {{(W-1){1'b0}}, e.dz});
          if (e.chk) begin
            check(quotient == e.q, "R1", $sformatf("quotient %h/%h", e.a, e.b),
                  quotient, e.q);
            check(remainder == e.r, "R2", $sformatf("remainder %h/%h", e.a, e.b),
                  remainder, e.r);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #3ms;
    nTests++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  logic [W-1:0] edgeVals [5] = '{16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF, 16'h0000};

  initial begin
    // R6: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R6", "outValid in reset", {{(W-1){1'b0}}, outValid}, '0);
    check(divZero == 1'b0, "R6", "divZero in reset", {{(W-1){1'b0}}, divZero}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R6", "outValid after reset", {{(W-1){1'b0}}, outValid}, '0);
    check(divZero == 1'b0, "R6", "divZero after reset", {{(W-1){1'b0}}, divZero}, '0);
    monOn = 1'b1;

    // R7: exact quotients with zero remainder
    drive(16'h2000, 16'h4000, 1'b1);
    drive(16'h4000, 16'h8000, 1'b1);
    drive(16'hE000, 16'h4000, 1'b1);
    drive(16'h0000, 16'h1234, 1'b1);
    drive(16'hC000, 16'h8000, 1'b1);
    drive(16'h0000, 16'h0000, 1'b0);
    repeat (LATENCY + 2) drive(16'h0, 16'h0, 1'b0);
    check(expQ.size() == 0, "R7", "exact cases drained", W'(expQ.size()), '0);

    // R4: edge-value pairs back to back, including zero divisors (R5)
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        drive(edgeVals[i], edgeVals[j], 1'b1);

    // Random pairs with random idle gaps (R8)
    for (int k = 0; k < 4000; k++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      if (k % 3 == 0) a = a >>> 3;
      if (k % 97 == 0) b = '0;
      drive(a, b, ($urandom % 10) >= 3);
    end

    // R8: idle input produces no output once drained
    repeat (LATENCY + 4) drive(16'h0, 16'h0, 1'b0);
    check(expQ.size() == 0, "R8", "all results delivered", W'(expQ.size()), '0);
    check(outValid == 1'b0, "R8", "outValid idle", {{(W-1){1'b0}}, outValid}, '0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule